// File: doc/BRIEF.md
# Adaptive Test-Clock Return and Edge Strobes

This block takes a slow test clock, together with its mode-select and serial-data lines, from an external debug probe into a much faster core clock domain. It passes all three lines through a resynchronizing flop chain before it looks for edges. From the synchronized test clock it makes two core-domain strobes, one for each rising edge and one for each falling edge. Each strobe is one core cycle wide. Downstream test-port logic samples the mode and data lines on the rising strobe and changes its serial output on the falling strobe.

The block also drives a return clock back to the probe. This output copies the synchronized test-clock level, so it goes high only after the core has registered a rising test-clock edge, and goes low only after the core has registered a falling one. A probe that paces itself waits for each return-clock rising edge before it sends its next test-clock rising edge. If the core clock is always at least ten times faster than the test clock, the probe may ignore the return clock.

The block has its own synchronous active-low reset. That reset is meant to be driven only by power-on or low-voltage detection, or by the test-reset pin. Watchdog and ordinary system resets do not reach it.

Top module: `adaptive_tck_return`

## Requirements
- R1: In the cycle after a core clock edge that sees `rst_n` low, `rtck_out`, `tck_rise_stb`, `tck_fall_stb`, `tms_cap`, `tdi_cap` and `tdo_out` are all 0.
- R2: A rise of `tck_in` set up before core edge k shows on `rtck_out` from core edge k+2 onward (two synchronizer flops plus one edge register). `rtck_out` is still 0 after edge k+1.
- R3: `tck_rise_stb` is 1 for exactly the one core cycle that follows edge k+2, the same edge at which `rtck_out` rises. It is never 1 together with `tck_fall_stb`.
- R4: A fall of `tck_in` set up before core edge k drops `rtck_out` at edge k+2, and raises `tck_fall_stb` for exactly that one cycle.
- R5: The `tms_in` and `tdi_in` values applied together with a `tck_in` rise appear on `tms_cap` and `tdi_cap` at edge k+3. These outputs do not change at any other time.
- R6: The `tdo_next` value present during the fall strobe appears on `tdo_out` at edge k+3 of that falling edge. `tdo_out` does not change at any other time.
- R7: While `tck_in` holds one level, no strobe is produced and `rtck_out` keeps its value, however long the hold and whatever `tms_in`, `tdi_in` and `tdo_next` do.
- R8: While `rst_n` is held low, toggling `tck_in` produces no strobe and `rtck_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset (global or test reset only) |
| tck_in | input | 1 | Test clock from the probe, asynchronous |
| tms_in | input | 1 | Test mode select from the probe, asynchronous |
| tdi_in | input | 1 | Test serial data in from the probe, asynchronous |
| tdo_next | input | 1 | Serial output bit offered by downstream test-port logic |
| rtck_out | output | 1 | Return clock to the probe |
| tck_rise_stb | output | 1 | One-cycle strobe per synchronized test-clock rise |
| tck_fall_stb | output | 1 | One-cycle strobe per synchronized test-clock fall |
| tms_cap | output | 1 | Mode-select bit sampled on the rise strobe |
| tdi_cap | output | 1 | Data-in bit sampled on the rise strobe |
| tdo_out | output | 1 | Serial output registered on the fall strobe |

## Verification
The bench runs the probe in paced mode with random hold times and random line values, and checks each edge's latency at the cycle before and the cycle of the return-clock change. A design with a missing or extra synchronizer stage fails there, as does one whose return clock follows the raw input. Long holds with busy data lines would expose strobes that fire on level rather than on edge, or captures that leak outside their strobe. Toggling the test clock while reset is held catches a design that lets the synchronizer or the return clock run during reset.

// File: rtl/atr_pkg.sv
// Package: shared constants and types for the adaptive test-clock return.
// Assumes: a single core clock domain, with all probe lines asynchronous to it.
package atr_pkg;

    // Number of resynchronizing flops on each probe line.
    parameter int unsigned ATR_SYNC_DEPTH = 2;

    // Number of probe lines that go through the synchronizer bank.
    localparam int unsigned ATR_PROBE_LINES = 3;

    // Bit positions of the probe lines inside the synchronizer bank.
    localparam int unsigned ATR_BIT_TCK = 0;
    localparam int unsigned ATR_BIT_TMS = 1;
    localparam int unsigned ATR_BIT_TDI = 2;

    // Edge strobes that the edge tracker passes to the capture stage.
    typedef struct packed {
        logic rise;
        logic fall;
    } atr_strobe_t;

endpackage

// File: rtl/atr_sync_bank.sv
// Module: multi-bit flop-chain resynchronizer.
// Purpose: brings WIDTH asynchronous single-bit lines into the clk domain
//          through DEPTH flops each.
// Assumes: each bit is independent (no multi-bit coherence is promised);
//          reset is synchronous and active low, and clears every stage.
module atr_sync_bank #(
    parameter int unsigned WIDTH = 3,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int unsigned LAST = DEPTH - 1;

    logic [WIDTH-1:0] stage_q [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop: samples the raw asynchronous lines.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                // Later flops: settle the previous stage's value.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[LAST];

endmodule

// File: rtl/atr_edge_track.sv
// Module: test-clock edge tracker and return-clock driver.
// Purpose: registers the synchronized test-clock level and turns each change
//          into a one-cycle strobe. The registered level is the return clock.
// Assumes: tck_sync is already in the clk domain.
module atr_edge_track
    import atr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tck_sync,
    output logic        rtck,
    output atr_strobe_t stb
);

    logic level_q;
    logic rise_q;
    logic fall_q;

    // Track level and build strobes; all are cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            level_q <= tck_sync;
            rise_q  <= tck_sync & ~level_q;
            fall_q  <= ~tck_sync & level_q;
        end
    end

    assign rtck     = level_q;
    assign stb.rise = rise_q;
    assign stb.fall = fall_q;

    AST_RISE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |=> !rise_q);                                   // R3
    AST_FALL_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_q |=> !fall_q);                                   // R4
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_q && fall_q));                                  // R3
    AST_RTCK_ROSE_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_q) |-> rise_q);                            // R2
    AST_RTCK_FELL_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level_q) |-> fall_q);                            // R4

endmodule

// File: rtl/atr_capture.sv
// Module: strobe-qualified capture of mode, data-in and serial-out bits.
// Purpose: samples mode and data-in on the rise strobe, and registers the
//          serial output on the fall strobe.
// Assumes: every input is already in the clk domain.
module atr_capture
    import atr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  atr_strobe_t stb,
    input  logic        tms_sync,
    input  logic        tdi_sync,
    input  logic        tdo_next,
    output logic        tms_cap,
    output logic        tdi_cap,
    output logic        tdo_out
);

    // Sample the probe inputs on a rise strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tms_cap <= 1'b0;
            tdi_cap <= 1'b0;
        end else if (stb.rise) begin
            tms_cap <= tms_sync;
            tdi_cap <= tdi_sync;
        end
    end

    // Update the serial output on a fall strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        tdo_out <= 1'b0;
        else if (stb.fall) tdo_out <= tdo_next;
    end

    AST_TMS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stb.rise |=> $stable(tms_cap));                       // R5
    AST_TDI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stb.rise |=> $stable(tdi_cap));                       // R5
    AST_TDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stb.fall |=> $stable(tdo_out));                       // R6

endmodule

// File: rtl/adaptive_tck_return.sv
// Module: top level of the adaptive test-clock return.
// Purpose: synchronizes the probe lines, returns a paced copy of the test
//          clock, and makes core-domain edge strobes and captured bits.
// Assumes: rst_n comes only from global power/voltage reset or the test-reset
//          pin; the core clock is several times faster than the test clock.
module adaptive_tck_return
    import atr_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = ATR_SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tck_in,
    input  logic tms_in,
    input  logic tdi_in,
    input  logic tdo_next,
    output logic rtck_out,
    output logic tck_rise_stb,
    output logic tck_fall_stb,
    output logic tms_cap,
    output logic tdi_cap,
    output logic tdo_out
);

    logic [ATR_PROBE_LINES-1:0] probe_raw;
    logic [ATR_PROBE_LINES-1:0] probe_sync;
    atr_strobe_t                stb;

    // Gather the asynchronous probe lines into one bank.
    always_comb begin
        probe_raw              = '0;
        probe_raw[ATR_BIT_TCK] = tck_in;
        probe_raw[ATR_BIT_TMS] = tms_in;
        probe_raw[ATR_BIT_TDI] = tdi_in;
    end

    atr_sync_bank #(
        .WIDTH (ATR_PROBE_LINES),
        .DEPTH (SYNC_DEPTH)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (probe_raw),
        .sync_out (probe_sync)
    );

    atr_edge_track u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .tck_sync (probe_sync[ATR_BIT_TCK]),
        .rtck     (rtck_out),
        .stb      (stb)
    );

    atr_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (stb),
        .tms_sync (probe_sync[ATR_BIT_TMS]),
        .tdi_sync (probe_sync[ATR_BIT_TDI]),
        .tdo_next (tdo_next),
        .tms_cap  (tms_cap),
        .tdi_cap  (tdi_cap),
        .tdo_out  (tdo_out)
    );

    assign tck_rise_stb = stb.rise;
    assign tck_fall_stb = stb.fall;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!rtck_out && !tck_rise_stb && !tck_fall_stb)); // R8
    AST_RESET_CLEARS_CAPTURE: assert property (@(posedge clk)
        !rst_n |=> (!tms_cap && !tdi_cap && !tdo_out));            // R1
    AST_RTCK_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tck_rise_stb && !tck_fall_stb) |-> $stable(rtck_out));   // R7

endmodule

// File: tb/tb_adaptive_tck_return.sv
module tb_adaptive_tck_return;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tck_in = 1'b0, tms_in = 1'b0, tdi_in = 1'b0, tdo_next = 1'b0;
    logic rtck_out, tck_rise_stb, tck_fall_stb, tms_cap, tdi_cap, tdo_out;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;

    // Values the outputs should hold, tracked by the bench from the requirements.
    logic exp_tms = 1'b0, exp_tdi = 1'b0, exp_tdo = 1'b0, exp_rtck = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    adaptive_tck_return dut (
        .clk(clk), .rst_n(rst_n), .tck_in(tck_in), .tms_in(tms_in),
        .tdi_in(tdi_in), .tdo_next(tdo_next), .rtck_out(rtck_out),
        .tck_rise_stb(tck_rise_stb), .tck_fall_stb(tck_fall_stb),
        .tms_cap(tms_cap), .tdi_cap(tdi_cap), .tdo_out(tdo_out)
    );

    // Pack the observable outputs for comparison.
    function automatic logic [5:0] pack_out(input logic r, input logic rs, input logic fs,
                                            input logic m, input logic d, input logic o);
        return {r, rs, fs, m, d, o};
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {rtck,rise,fall,tms,tdi,tdo} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [5:0] now_out();
        return pack_out(rtck_out, tck_rise_stb, tck_fall_stb, tms_cap, tdi_cap, tdo_out);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Hold every level for n cycles while the data lines churn; nothing may move (R7).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            tms_in   = 1'($urandom);
            tdi_in   = 1'($urandom);
            tdo_next = 1'($urandom);
            step();
            check("R7", now_out(), pack_out(exp_rtck, 1'b0, 1'b0, exp_tms, exp_tdi, exp_tdo));
        end
    endtask

    // One paced rising edge with given mode/data bits (R2, R3, R5).
    task automatic tck_rise(input logic m, input logic d);
        tck_in = 1'b1; tms_in = m; tdi_in = d;        // set up before edge k
        step();                                        // after edge k
        step();                                        // after edge k+1
        check("R2", now_out(), pack_out(1'b0, 1'b0, 1'b0, exp_tms, exp_tdi, exp_tdo));
        step();                                        // after edge k+2
        exp_rtck = 1'b1;
        check("R3", now_out(), pack_out(1'b1, 1'b1, 1'b0, exp_tms, exp_tdi, exp_tdo));
        step();                                        // after edge k+3
        exp_tms = m; exp_tdi = d;
        check("R5", now_out(), pack_out(1'b1, 1'b0, 1'b0, exp_tms, exp_tdi, exp_tdo));
    endtask

    // One falling edge; tdo_next held through the fall strobe (R4, R6).
    task automatic tck_fall(input logic o);
        tck_in = 1'b0; tdo_next = o;
        step();
        step();
        check("R4", now_out(), pack_out(1'b1, 1'b0, 1'b0, exp_tms, exp_tdi, exp_tdo));
        step();
        exp_rtck = 1'b0;
        check("R4", now_out(), pack_out(1'b0, 1'b0, 1'b1, exp_tms, exp_tdi, exp_tdo));
        step();
        exp_tdo = o;
        check("R6", now_out(), pack_out(1'b0, 1'b0, 1'b0, exp_tms, exp_tdi, exp_tdo));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        tck_in = 1'b1; tms_in = 1'b1; tdi_in = 1'b1; tdo_next = 1'b1;
        step(); step(); step();
        check("R1", now_out(), 6'b000000);
        tck_in = 1'b0;
        step(); step(); step();
        rst_n = 1'b1;
        step();
        check("R1", now_out(), 6'b000000);

        // Directed corners: each data pattern and an immediate turnaround.
        tck_rise(1'b1, 1'b0); tck_fall(1'b1);
        tck_rise(1'b0, 1'b1); tck_fall(1'b0);
        tck_rise(1'b1, 1'b1); idle(40); tck_fall(1'b1); idle(40);

        // Random paced traffic.
        for (int t = 0; t < 300; t++) begin
            tck_rise(1'($urandom), 1'($urandom));
            idle($urandom_range(0, 6));
            tck_fall(1'($urandom));
            idle($urandom_range(0, 6));
        end

        // Reset held while the test clock toggles (R8).
        tck_rise(1'b1, 1'b1); tck_fall(1'b1);
        rst_n = 1'b0;
        for (int i = 0; i < 40; i++) begin
            tck_in = ((i / 3) % 2) == 1;
            tms_in = 1'($urandom); tdi_in = 1'($urandom); tdo_next = 1'($urandom);
            step();
            check("R8", now_out(), 6'b000000);
        end
        tck_in = 1'b0;
        step(); step(); step();
        rst_n = 1'b1;
        exp_rtck = 1'b0; exp_tms = 1'b0; exp_tdi = 1'b0; exp_tdo = 1'b0;
        idle(5);
        tck_rise(1'b0, 1'b1); tck_fall(1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule